// File: doc/BRIEF.md
# Encoded ROM Read Path

This block is the synchronous read side of a small constant ROM whose contents are kept in a transformed form, so that fewer ones are stored. A read request carries an address. The block looks up the stored word and removes the transformations. It then returns the original two's-complement value, registered, together with a one-cycle valid pulse.

Three static parameters describe how the image is transformed. The first chooses whether the whole array is kept complemented. The second chooses how values are coded: plain two's complement, sign and magnitude, or differences between neighbouring addresses. Every stored row is one bit wider than the data and carries a flag that marks a row kept complemented.

In difference mode, every BASE_STRIDE-th address holds an absolute value. A read that is neither sequential nor on such an anchor makes the block walk forward from the nearest anchor below it. It reports `busy` while it does so. A read of the address that was just read leaves the output and the accumulator untouched.

Top module: `enc_rom_rdpath`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rd_valid` and `busy` are 0 and `rd_data` is 0.
- R2: With INVERT_ARRAY set, every bit of the stored (DATA_W+1)-bit word, including the row flag, is complemented before any other decode step.
- R3: Bit DATA_W of the stored word (after R2) is the row flag. When it is 1, the low DATA_W payload bits are complemented; when it is 0, they pass unchanged.
- R4: In sign-magnitude coding, payload bit DATA_W-1 is the sign and the lower bits are the magnitude. The output is the two's-complement value, and this conversion comes after R2 and R3.
- R5: A sign-magnitude payload with the sign set and a zero magnitude reads out as 0.
- R6: In the two non-difference codings, a read accepted at a clock edge presents `rd_valid` high, with its data, from that edge for exactly one cycle. `busy` stays 0.
- R7: In difference coding, an anchor address (low log2(BASE_STRIDE) address bits zero) loads its absolute value. A read at last address + 1 (modulo DEPTH) adds the stored difference to the previous result. Both complete with one-cycle latency.
- R8: In difference coding, any other address raises `busy`. The result appears k cycles after the accepting edge, where k is the address offset from its anchor.
- R9: `restart`, alone or together with a read, discards the access history. The next read is then treated as neither a repeat nor sequential.
- R10: A read of the same address as the previous accepted read, with no `restart` in between, gives a `rd_valid` pulse while `rd_data` stays unchanged. In difference mode, nothing is added.
- R11: `rd_en` asserted while `busy` is high is ignored. It produces no result and does not change the access history.
- R12: `rd_data` changes only in a cycle where `rd_valid` is high, and `rd_valid` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| restart | input | 1 | Discard access history |
| rd_data | output | DATA_W | Decoded two's-complement word |
| rd_valid | output | 1 | One-cycle pulse with each result |
| busy | output | 1 | Difference-mode catch-up walk in progress |

## Verification
The bench builds three copies with DATA_W 8, DEPTH 32 and BASE_STRIDE 8. The first is a plain two's-complement copy. The second uses sign-magnitude coding with the whole array complemented. The third uses difference coding without array inversion. Because the stride is 8, walks of every length from 2 to 7 cycles are reachable, as are address wrap from 31 to 0 and anchor reloads at 0, 8, 16 and 24. The stored contents place value zero at odd addresses, where the sign-magnitude image records a negative zero. Row flags are set wherever a payload has more than four ones, so flagged and unflagged rows occur in all three copies.

// File: rtl/enc_rom_pkg.sv
package enc_rom_pkg;

  // How values are coded in the stored image
  typedef enum logic [1:0] {
    VC_TWOS    = 2'd0,
    VC_SIGNMAG = 2'd1,
    VC_DELTA   = 2'd2
  } value_code_e;

endpackage

// File: rtl/enc_rom_image.sv
module enc_rom_image
  import enc_rom_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          DEPTH        = 32,
  parameter int          BASE_STRIDE  = 8,
  parameter bit          INVERT_ARRAY = 1'b0,
  parameter value_code_e VALUE_CODE   = VC_DELTA,
  localparam int         ADDR_W       = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W:0]   rom_word
);

  // Original content of each location
  function automatic logic [DATA_W-1:0] plain_word(int a);
    int t;
    if (a % 7 == 5) return '0;
    t = (a * 37 + 11) % (2 ** DATA_W);
    if (t == 2 ** (DATA_W - 1)) t = 0;
    return DATA_W'(t);
  endfunction

  // Stored form: value code, then row flag, then optional array inversion
  function automatic logic [DATA_W:0] encode_word(int a);
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] p;
    logic              flag;
    logic [DATA_W:0]   w;
    v = plain_word(a);
    case (VALUE_CODE)
      VC_SIGNMAG: begin
        mag = ~v + 1'b1;
        if (v[DATA_W-1])
          p = {1'b1, mag[DATA_W-2:0]};
        else if (v == '0 && (a % 2 == 1))
          p = {1'b1, {(DATA_W-1){1'b0}}};
        else
          p = v;
      end
      VC_DELTA: begin
        if (a % BASE_STRIDE == 0) p = v;
        else                      p = v - plain_word(a - 1);
      end
      default: p = v;
    endcase
    flag = ($countones(p) > DATA_W / 2);
    if (flag) p = ~p;
    w = {flag, p};
    if (INVERT_ARRAY) w = ~w;
    return w;
  endfunction

  logic [DATA_W:0] image [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_row
    assign image[a] = encode_word(a);
  end

  assign rom_word = image[rom_addr];

endmodule

// File: rtl/enc_rom_unpack.sv
module enc_rom_unpack #(
  parameter int DATA_W       = 8,
  parameter bit INVERT_ARRAY = 1'b0,
  parameter bit SIGN_MAG     = 1'b0
) (
  input  logic [DATA_W:0]   raw_word,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W:0]   uninv;
  logic [DATA_W-1:0] payload;

  // Step 1: whole-array inversion
  if (INVERT_ARRAY) begin : g_inv
    assign uninv = ~raw_word;
  end else begin : g_noinv
    assign uninv = raw_word;
  end

  // Step 2: per-row inversion under the flag bit
  assign payload = uninv[DATA_W-1:0] ^ {DATA_W{uninv[DATA_W]}};

  // Step 3: sign-magnitude to two's complement
  if (SIGN_MAG) begin : g_sm
    logic [DATA_W-1:0] mag;
    assign mag   = {1'b0, payload[DATA_W-2:0]};
    assign value = payload[DATA_W-1] ? (~mag + 1'b1) : mag;
  end else begin : g_tc
    assign value = payload;
  end

endmodule

// File: rtl/enc_rom_ctrl.sv
module enc_rom_ctrl #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int STRIDE_W = 3,
  parameter bit IS_DELTA = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              restart,
  input  logic [DATA_W-1:0] word_val,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy
);

  logic [ADDR_W-1:0] last_addr, ptr, target, base_addr;
  logic              last_ok, walking;
  logic [DATA_W-1:0] acc, sum, data_q;
  logic              valid_q;
  logic              accept, fresh, hit_same, hit_next, at_base, start_walk;

  assign accept     = rd_en & ~walking;
  assign fresh      = last_ok & ~restart;
  assign hit_same   = fresh & (rd_addr == last_addr);
  assign hit_next   = fresh & (rd_addr == last_addr + 1'b1);
  assign at_base    = (rd_addr[STRIDE_W-1:0] == '0);
  assign base_addr  = {rd_addr[ADDR_W-1:STRIDE_W], {STRIDE_W{1'b0}}};
  assign start_walk = IS_DELTA & accept & ~hit_same & ~at_base & ~hit_next;
  assign sum        = acc + word_val;

  always_comb begin
    if (walking)         rom_addr = ptr;
    else if (start_walk) rom_addr = base_addr;
    else                 rom_addr = rd_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_ok   <= 1'b0;
      walking   <= 1'b0;
      ptr       <= '0;
      target    <= '0;
      acc       <= '0;
      data_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (restart && !walking) last_ok <= 1'b0;
      if (walking) begin
        acc <= sum;
        if (ptr == target) begin
          walking <= 1'b0;
          data_q  <= sum;
          valid_q <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end else if (accept) begin
        if (hit_same) begin
          valid_q <= 1'b1;
        end else begin
          last_addr <= rd_addr;
          last_ok   <= 1'b1;
          if (!IS_DELTA) begin
            data_q  <= word_val;
            valid_q <= 1'b1;
          end else if (start_walk) begin
            acc     <= word_val;
            ptr     <= base_addr + 1'b1;
            target  <= rd_addr;
            walking <= 1'b1;
          end else if (at_base) begin
            acc     <= word_val;
            data_q  <= word_val;
            valid_q <= 1'b1;
          end else begin
            acc     <= sum;
            data_q  <= sum;
            valid_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
  assign busy     = walking;

endmodule

// File: rtl/enc_rom_rdpath.sv
module enc_rom_rdpath
  import enc_rom_pkg::*;
#(
  parameter int          DATA_W       = 8,
  parameter int          DEPTH        = 32,
  parameter int          BASE_STRIDE  = 8,
  parameter bit          INVERT_ARRAY = 1'b0,
  parameter value_code_e VALUE_CODE   = VC_DELTA,
  localparam int         ADDR_W       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              restart,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy
);

  localparam int STRIDE_W = $clog2(BASE_STRIDE);
  localparam bit IS_DELTA = (VALUE_CODE == VC_DELTA);
  localparam bit SIGN_MAG = (VALUE_CODE == VC_SIGNMAG);

  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W:0]   rom_word;
  logic [DATA_W-1:0] word_val;

  enc_rom_image #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_STRIDE(BASE_STRIDE),
    .INVERT_ARRAY(INVERT_ARRAY), .VALUE_CODE(VALUE_CODE)
  ) u_image (
    .rom_addr(rom_addr),
    .rom_word(rom_word)
  );

  enc_rom_unpack #(
    .DATA_W(DATA_W), .INVERT_ARRAY(INVERT_ARRAY), .SIGN_MAG(SIGN_MAG)
  ) u_unpack (
    .raw_word(rom_word),
    .value(word_val)
  );

  enc_rom_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .IS_DELTA(IS_DELTA)
  ) u_ctrl (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .restart(restart),
    .word_val(word_val), .rom_addr(rom_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

endmodule

// File: rtl/enc_rom_rdpath_chk.sv
module enc_rom_rdpath_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter bit IS_DELTA = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              restart,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              busy
);

  // R12
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));

  // R12
  valid_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rd_valid);

  // R10
  repeat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !busy && !restart && $past(rd_en && !busy && !restart && !rst)
     && rd_addr == $past(rd_addr)) |=> (rd_valid && $stable(rd_data)));

  // R8
  walk_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(rd_en));

  if (!IS_DELTA) begin : g_flat
    // R6
    flat_latency_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_valid);
    // R6
    flat_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
      !busy);
  end

endmodule

bind enc_rom_rdpath enc_rom_rdpath_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IS_DELTA(VALUE_CODE == enc_rom_pkg::VC_DELTA)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .restart(restart),
  .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
);

// File: tb/test_enc_rom_rdpath.sv
module test_enc_rom_rdpath;
  import enc_rom_pkg::*;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 32;
  localparam int STRIDE = 8;
  localparam int ADDR_W = 5;

  // {restart, addr}
  localparam logic [5:0] VEC [16] = '{
    6'd0, 6'd1, 6'd2, 6'd3, 6'd3, 6'd13, 6'd14, 6'd5,
    6'd5, {1'b1, 5'd5}, 6'd16, 6'd31, 6'd0, 6'd26, 6'd27, 6'd19
  };

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en_d = 1'b0, rd_en_n = 1'b0, restart = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] d_d, tc_d, sm_d;
  logic d_v, d_b, tc_v, tc_b, sm_v, sm_b;

  int checks = 0, errors = 0;
  int b_last = 0;
  bit b_ok = 0, done = 0;

  always #4 clk = ~clk;

  enc_rom_rdpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_STRIDE(STRIDE),
    .INVERT_ARRAY(1'b0), .VALUE_CODE(VC_DELTA)) i_enc_rom_rdpath (
    .clk(clk), .rst(rst), .rd_en(rd_en_d), .rd_addr(rd_addr), .restart(restart),
    .rd_data(d_d), .rd_valid(d_v), .busy(d_b));

  enc_rom_rdpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_STRIDE(STRIDE),
    .INVERT_ARRAY(1'b0), .VALUE_CODE(VC_TWOS)) i_enc_rom_rdpath_tc (
    .clk(clk), .rst(rst), .rd_en(rd_en_n), .rd_addr(rd_addr), .restart(restart),
    .rd_data(tc_d), .rd_valid(tc_v), .busy(tc_b));

  enc_rom_rdpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_STRIDE(STRIDE),
    .INVERT_ARRAY(1'b1), .VALUE_CODE(VC_SIGNMAG)) i_enc_rom_rdpath_sm (
    .clk(clk), .rst(rst), .rd_en(rd_en_n), .rd_addr(rd_addr), .restart(restart),
    .rd_data(sm_d), .rd_valid(sm_v), .busy(sm_b));

  function automatic int ref_val(int a);
    int t;
    if (a % 7 == 5) return 0;
    t = (a * 37 + 11) % 256;
    if (t == 128) t = 0;
    return t;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_read(int a, bit rs, output int cnt);
    int  want;
    bit  fresh, rep;
    string tagd, tagsm;
    fresh = b_ok && !rs;
    rep   = fresh && (a == b_last);
    if (rep || (a % STRIDE == 0) || (fresh && a == (b_last + 1) % DEPTH)) want = 0;
    else want = a % STRIDE;
    tagsm = (a % 7 == 5 && a % 2 == 1) ? "R5" : "R4";
    tagd  = rs ? "R9" : (rep ? "R10" : (want > 0 ? "R8" : "R7"));
    @(negedge clk);
    rd_addr = a[ADDR_W-1:0]; restart = rs; rd_en_d = 1'b1; rd_en_n = 1'b1;
    @(negedge clk);
    rd_en_d = 1'b0; rd_en_n = 1'b0; restart = 1'b0;
    check("R6", "tc valid", int'(tc_v), 1);
    check("R6", "tc busy", int'(tc_b), 0);
    check("R3", "tc data", int'(tc_d), ref_val(a));
    check("R2", "sm valid", int'(sm_v), 1);
    check(tagsm, "sm data", int'(sm_d), ref_val(a));
    if (want > 0) check("R8", "delta busy", int'(d_b), 1);
    cnt = 0;
    while (!d_v && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(tagd, "delta latency", cnt, want);
    check(tagd, "delta data", int'(d_d), ref_val(a));
    b_last = a;
    b_ok   = 1'b1;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "valid in reset", int'(d_v | tc_v | sm_v), 0);
    check("R1", "busy in reset", int'(d_b | tc_b | sm_b), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "data after reset", int'(d_d) + int'(tc_d) + int'(sm_d), 0);
    check("R1", "valid after reset", int'(d_v | tc_v | sm_v), 0);

    for (int i = 0; i < 16; i++) begin
      do_read(int'(VEC[i][4:0]), VEC[i][5], cnt);
      @(negedge clk);
      check("R12", "valid pulse ends", int'(d_v | tc_v | sm_v), 0);
    end

    // R11: read strobe during a walk is ignored
    @(negedge clk);
    rd_addr = 5'd13; restart = 1'b1; rd_en_d = 1'b1;
    @(negedge clk);
    restart = 1'b0; rd_addr = 5'd24;
    cnt = 0;
    @(negedge clk);
    cnt++;
    rd_en_d = 1'b0;
    while (!d_v && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check("R11", "walk latency with stray strobe", cnt, 5);
    check("R11", "walk data with stray strobe", int'(d_d), ref_val(13));
    @(negedge clk);
    check("R11", "no extra result", int'(d_v), 0);
    check("R11", "data unchanged", int'(d_d), ref_val(13));
    b_last = 13; b_ok = 1'b1;
    do_read(14, 1'b0, cnt);
    check("R11", "history kept at 13", cnt, 0);

    // R9: restart alone breaks the sequential chain
    do_read(20, 1'b0, cnt);
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    b_ok = 1'b0;
    do_read(21, 1'b0, cnt);
    check("R9", "walk after lone restart", cnt, 5);

    // R10: back-to-back repeat with no idle cycle
    @(negedge clk);
    rd_addr = 5'd8; rd_en_d = 1'b1;
    @(negedge clk);
    check("R7", "anchor load", int'(d_d), ref_val(8));
    @(negedge clk);
    rd_en_d = 1'b0;
    check("R10", "repeat valid", int'(d_v), 1);
    check("R10", "repeat data", int'(d_d), ref_val(8));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule